// File: doc/BRIEF.md
# Interrupt Entry Gating and Sequencing

This block sits beside the instruction sequencer of a small 8-bit processor core. At every instruction boundary it decides whether to begin an interrupt entry and of which kind. It considers a latched non-maskable request, a level-sensitive maskable request line, and a software break opcode that has just been decoded. Once it has decided, it steps through a short entry sequence. The sequence gives the cycles in which the return address is pushed, then the cycle in which the status byte is pushed (with the break-marker bit value to store), then the cycle in which a vector is selected and the interrupt-disable flag must be set.

Masking of the maskable line follows the interrupt-disable flag with a one-instruction lag when the flag was written by a set-disable, clear-disable or status-pull instruction. Other changes take effect at once. A non-maskable request that arrives while a break entry is underway takes over that entry's vector. The break marker already chosen stays 1.

Top module: `irq_entry_ctrl`

## Requirements
- R1: With the interrupt-disable mask clear and `irq_n_i` low at a boundary, an entry starts whose vector output is `vec_nmi_o` = 0 (shared maskable/break vector) and whose pushed marker `b_bit_o` is 0.
- R2: A set mask blocks only the maskable line. A latched non-maskable request or `brk_i` at a boundary still starts an entry.
- R3: When `i_dly_chg_i` is 1 at a boundary (the completed instruction was set-disable, clear-disable or status-pull), masking at that boundary uses the flag value seen at the previous boundary. The new value applies from the following boundary.
- R4: When `i_dly_chg_i` is 0, masking at a boundary uses `i_flag_i` directly. An entry also masks the maskable line immediately through its own set-disable step.
- R5: Non-maskable requests are taken on a falling edge of `nmi_n_i` and held until serviced. A low level held across boundaries gives only one entry. Priority at a boundary is non-maskable, then maskable, then break.
- R6: The pushed marker is 1 only for a break entry. A non-maskable entry drives `vec_nmi_o` = 1.
- R7: A non-maskable request latched before the vector step of a break entry gives `vec_nmi_o` = 1 with the pushed marker still 1, and that request is consumed.
- R8: A non-maskable request arriving during a maskable entry does not change that entry's vector. It is taken at the next boundary.
- R9: `start_o` pulses one cycle after the deciding boundary. `push_ret_o` is high for `PC_BYTES` cycles, then `push_stat_o` for one cycle, then `vec_valid_o` together with `set_i_o` for one cycle. Boundaries during a sequence are ignored.
- R10: Synchronous active-low reset drives all outputs low, clears any latched non-maskable request without creating an edge from a line held low, and sets the delayed mask copy to masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | One-cycle strobe: an instruction has completed |
| irq_n_i | input | 1 | Maskable request, active low, level sensitive |
| nmi_n_i | input | 1 | Non-maskable request, active low, falling-edge taken |
| brk_i | input | 1 | The next opcode is a software break |
| i_flag_i | input | 1 | Current interrupt-disable flag |
| i_dly_chg_i | input | 1 | Completed instruction wrote the flag by an instruction with delayed effect |
| start_o | output | 1 | Entry start pulse |
| push_ret_o | output | 1 | Return-address push cycle |
| push_stat_o | output | 1 | Status push cycle |
| b_bit_o | output | 1 | Break marker to store, valid with `push_stat_o` |
| vec_valid_o | output | 1 | Vector select step |
| vec_nmi_o | output | 1 | 1 selects the non-maskable vector |
| set_i_o | output | 1 | Request to set the interrupt-disable flag |

## Verification
The bench builds the block with `PC_BYTES` = 2, which makes the status push fall in the third cycle after the boundary and the vector step in the fourth. That leaves a two-cycle window in which a falling request can be injected during a break or maskable entry. With this spacing the takeover case and the stays-pending case can be reached with exact cycle timing. The table covers the priority and masking combinations, including the delayed and immediate flag paths. Directed runs then cover reset, takeover, a held-low request, and boundaries arriving mid-sequence.

// File: rtl/irqseq_pkg.sv
`timescale 1ns/1ps
// Shared types for the interrupt entry controller.
// Assumes: nothing beyond standard SystemVerilog.
package irqseq_pkg;
    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_NMI  = 2'd1,
        K_IRQ  = 2'd2,
        K_BRK  = 2'd3
    } entry_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RET  = 2'd1,
        ST_STAT = 2'd2,
        ST_VEC  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/nmi_edge_latch.sv
`timescale 1ns/1ps
// Detects falling edges on the non-maskable request line and holds a
// pending flag until the sequencer consumes it.
// Assumes: nmi_n_i is already synchronous to clk.
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall   = prev_q & ~nmi_n_i;
    assign pend_o = pend_q;

    // Track the line and latch edges; a new edge wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= nmi_n_i;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_n_i;
            if (fall)       pend_q <= 1'b1;
            else if (clr_i) pend_q <= 1'b0;
        end
    end

    assert_nmi_edge_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_q && !nmi_n_i) |=> pend_o);
    assert_nmi_held_until_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/irq_mask_delay.sv
`timescale 1ns/1ps
// Produces the maskable-request grant using the interrupt-disable flag,
// delayed by one instruction when an instruction with delayed effect
// wrote it.
// Assumes: boundary_i never coincides with set_i_i.
module irq_mask_delay (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic irq_n_i,
    input  logic i_flag_i,
    input  logic i_dly_chg_i,
    input  logic set_i_i,
    output logic irq_ok_o
);
    logic prev_i_q;
    logic eff_mask;

    // Choose the flag value that governs masking at this boundary.
    always_comb begin
        eff_mask = i_dly_chg_i ? prev_i_q : i_flag_i;
        irq_ok_o = ~irq_n_i & ~eff_mask;
    end

    // Remember the flag seen at each boundary; entry masks at once.
    always_ff @(posedge clk) begin
        if (!rst_n)          prev_i_q <= 1'b1;
        else if (set_i_i)    prev_i_q <= 1'b1;
        else if (boundary_i) prev_i_q <= i_flag_i;
    end

    assert_delay_copy_masked_after_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i_i |=> (i_dly_chg_i || i_flag_i || !irq_ok_o || !prev_i_q || 1'b1) && prev_i_q);
endmodule

// File: rtl/entry_seq.sv
`timescale 1ns/1ps
// Picks the entry kind at a boundary and steps through the entry:
// return-address pushes, status push, vector select with flag set.
// Assumes: PC_BYTES >= 1; boundary strobes during a sequence are dropped.
module entry_seq #(
    parameter int PC_BYTES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic nmi_pend_i,
    input  logic irq_ok_i,
    input  logic brk_i,
    output logic nmi_clr_o,
    output logic start_o,
    output logic push_ret_o,
    output logic push_stat_o,
    output logic b_bit_o,
    output logic vec_valid_o,
    output logic vec_nmi_o,
    output logic set_i_o
);
    import irqseq_pkg::*;

    localparam int CW = (PC_BYTES < 2) ? 1 : $clog2(PC_BYTES);
    localparam logic [CW-1:0] LAST_RET = CW'(PC_BYTES - 1);

    seq_state_t  state_q;
    entry_kind_t kind_q;
    entry_kind_t sel;
    logic [CW-1:0] cnt_q;
    logic start_q;
    logic take;
    logic hijack;

    // Priority pick among the requests present at the boundary.
    always_comb begin
        if (nmi_pend_i)    sel = K_NMI;
        else if (irq_ok_i) sel = K_IRQ;
        else if (brk_i)    sel = K_BRK;
        else               sel = K_NONE;
    end

    // Decode the step outputs and the late vector takeover.
    always_comb begin
        take        = boundary_i && (state_q == ST_IDLE) && (sel != K_NONE);
        hijack      = (state_q == ST_VEC) && (kind_q == K_BRK) && nmi_pend_i;
        nmi_clr_o   = (take && (sel == K_NMI)) || hijack;
        start_o     = start_q;
        push_ret_o  = (state_q == ST_RET);
        push_stat_o = (state_q == ST_STAT);
        b_bit_o     = push_stat_o && (kind_q == K_BRK);
        vec_valid_o = (state_q == ST_VEC);
        vec_nmi_o   = vec_valid_o && ((kind_q == K_NMI) || hijack);
        set_i_o     = vec_valid_o;
    end

    // Sequence state, kind capture and return-byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_NONE;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= take;
            case (state_q)
                ST_IDLE: if (take) begin
                    state_q <= ST_RET;
                    kind_q  <= sel;
                    cnt_q   <= '0;
                end
                ST_RET: begin
                    if (cnt_q == LAST_RET) state_q <= ST_STAT;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                ST_STAT: state_q <= ST_VEC;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_start_follows_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(boundary_i));
    assert_flag_set_after_status_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_stat_o |=> (vec_valid_o && set_i_o));
    assert_takeover_keeps_marker_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_stat_o && b_bit_o && nmi_pend_i) |=> vec_nmi_o);
    assert_start_is_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/irq_entry_ctrl.sv
`timescale 1ns/1ps
// Top of the interrupt entry controller: edge latch for the
// non-maskable line, delayed mask for the maskable line, and the
// entry sequencer.
// Assumes: all inputs are synchronous to clk.
module irq_entry_ctrl #(
    parameter int PC_BYTES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary_i,
    input  logic irq_n_i,
    input  logic nmi_n_i,
    input  logic brk_i,
    input  logic i_flag_i,
    input  logic i_dly_chg_i,
    output logic start_o,
    output logic push_ret_o,
    output logic push_stat_o,
    output logic b_bit_o,
    output logic vec_valid_o,
    output logic vec_nmi_o,
    output logic set_i_o
);
    logic nmi_pend;
    logic nmi_clr;
    logic irq_ok;

    nmi_edge_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n_i (nmi_n_i),
        .clr_i   (nmi_clr),
        .pend_o  (nmi_pend)
    );

    irq_mask_delay u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (boundary_i),
        .irq_n_i     (irq_n_i),
        .i_flag_i    (i_flag_i),
        .i_dly_chg_i (i_dly_chg_i),
        .set_i_i     (set_i_o),
        .irq_ok_o    (irq_ok)
    );

    entry_seq #(.PC_BYTES(PC_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (boundary_i),
        .nmi_pend_i  (nmi_pend),
        .irq_ok_i    (irq_ok),
        .brk_i       (brk_i),
        .nmi_clr_o   (nmi_clr),
        .start_o     (start_o),
        .push_ret_o  (push_ret_o),
        .push_stat_o (push_stat_o),
        .b_bit_o     (b_bit_o),
        .vec_valid_o (vec_valid_o),
        .vec_nmi_o   (vec_nmi_o),
        .set_i_o     (set_i_o)
    );

    assert_marker_only_in_status_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        b_bit_o |-> (push_stat_o && !vec_valid_o && !push_ret_o));
    assert_vector_after_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> $past(push_stat_o));
endmodule

// File: tb/sim_irq_entry_ctrl.sv
`timescale 1ns/1ps
module sim_irq_entry_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary_i = 1'b0, irq_n_i = 1'b1, nmi_n_i = 1'b1, brk_i = 1'b0;
    logic i_flag_i = 1'b1, i_dly_chg_i = 1'b0;
    logic start_o, push_ret_o, push_stat_o, b_bit_o, vec_valid_o, vec_nmi_o, set_i_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_entry_ctrl #(.PC_BYTES(2)) u0 (.*);

    // bits: pre_i, i, dly, irq_n, brk, nmi_fall | take, vec_nmi, b
    localparam logic [8:0] TBL [12] = '{
        9'b000100_000, // nothing pending                     R1
        9'b000000_100, // unmasked maskable line              R1
        9'b110000_000, // masked maskable line                R2
        9'b110010_101, // break ignores mask                  R2 R6
        9'b110101_110, // non-maskable ignores mask           R2 R6
        9'b000001_110, // non-maskable beats maskable         R5
        9'b000111_110, // non-maskable beats break            R5
        9'b000010_100, // maskable beats break                R5
        9'b101000_000, // clear-disable, delayed              R3
        9'b011000_100, // set-disable, one slips through      R3
        9'b100000_100, // immediate clear                     R4
        9'b010000_000  // immediate set                       R4
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_boundary(input logic i, input logic dly, input logic irqn, input logic brk);
        i_flag_i = i; i_dly_chg_i = dly; irq_n_i = irqn; brk_i = brk;
        boundary_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        boundary_i = 1'b0; brk_i = 1'b0; i_dly_chg_i = 1'b0;
    endtask

    // Sample six cycles, starting at the first negedge after the boundary.
    task automatic observe(output int st, output int ps, output int vc,
                           output int b, output int vn, output int si, output int nst);
        st = 0; ps = 0; vc = 0; b = 0; vn = 0; si = 0; nst = 0;
        for (int c = 1; c <= 6; c++) begin
            if (start_o) begin nst++; if (st == 0) st = c; end
            if (push_stat_o) begin ps = c; b = b_bit_o; end
            if (vec_valid_o) begin vc = c; vn = vec_nmi_o; si = set_i_o; end
            @(negedge clk);
        end
    endtask

    task automatic expect_entry(input string tag, input int take, input int evn, input int eb);
        int st, ps, vc, b, vn, si, nst;
        observe(st, ps, vc, b, vn, si, nst);
        chk({tag, " start"}, (st == 1) ? 1 : 0, take);
        if (take != 0) begin
            chk({tag, " R9 status push cycle"}, ps, 3);
            chk({tag, " R9 vector cycle"}, vc, 4);
            chk({tag, " R9 set flag"}, si, 1);
            chk({tag, " vector"}, vn, evn);
            chk({tag, " marker"}, b, eb);
        end
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int st, ps, vc, b, vn, si, nst;
        // R10: reset with both request lines low
        nmi_n_i = 1'b0; irq_n_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 outputs after reset", {start_o, push_ret_o, push_stat_o, b_bit_o,
            vec_valid_o, vec_nmi_o, set_i_o}, 0);
        pulse_boundary(1'b0, 1'b1, 1'b0, 1'b0);
        expect_entry("R10 delayed copy masked and no false edge", 0, 0, 0);
        nmi_n_i = 1'b1; irq_n_i = 1'b1;
        @(negedge clk);

        for (int r = 0; r < 12; r++) begin
            logic [8:0] v;
            v = TBL[r];
            pulse_boundary(v[8], 1'b0, 1'b1, 1'b0);
            observe(st, ps, vc, b, vn, si, nst);
            if (v[3]) begin nmi_n_i = 1'b0; @(negedge clk); end
            pulse_boundary(v[7], v[6], v[5], v[4]);
            expect_entry($sformatf("table row %0d R1 R2 R3 R4 R5 R6", r), int'(v[2]), int'(v[1]), int'(v[0]));
            nmi_n_i = 1'b1; irq_n_i = 1'b1;
            @(negedge clk);
        end

        // R7: takeover of a break entry
        pulse_boundary(1'b1, 1'b0, 1'b1, 1'b1);
        nmi_n_i = 1'b0;
        expect_entry("R7 takeover", 1, 1, 1);
        nmi_n_i = 1'b1;
        pulse_boundary(1'b1, 1'b0, 1'b1, 1'b0);
        expect_entry("R7 request consumed", 0, 0, 0);

        // R8: request during maskable entry stays pending
        pulse_boundary(1'b0, 1'b0, 1'b0, 1'b0);
        nmi_n_i = 1'b0;
        expect_entry("R8 maskable entry keeps vector", 1, 0, 0);
        nmi_n_i = 1'b1; irq_n_i = 1'b1;
        pulse_boundary(1'b1, 1'b0, 1'b1, 1'b0);
        expect_entry("R8 pending taken next", 1, 1, 0);

        // R5: held low level gives one entry
        nmi_n_i = 1'b0;
        @(negedge clk);
        pulse_boundary(1'b1, 1'b0, 1'b1, 1'b0);
        expect_entry("R5 held level first", 1, 1, 0);
        pulse_boundary(1'b1, 1'b0, 1'b1, 1'b0);
        expect_entry("R5 held level second", 0, 0, 0);
        nmi_n_i = 1'b1;

        // R9: boundary during a sequence is ignored
        pulse_boundary(1'b1, 1'b0, 1'b1, 1'b1);
        boundary_i = 1'b1; brk_i = 1'b1;
        @(negedge clk);
        boundary_i = 1'b0; brk_i = 1'b0;
        observe(st, ps, vc, b, vn, si, nst);
        chk("R9 mid-sequence boundary ignored", nst, 0);

        // R10: reset clears a latched request
        nmi_n_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        nmi_n_i = 1'b1;
        @(negedge clk);
        pulse_boundary(1'b1, 1'b0, 1'b1, 1'b0);
        expect_entry("R10 latch cleared", 0, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule